// File: doc/BRIEF.md
# Dual-Plane Memory Slave for a Multiplexed Address/Data Bus

This block sits on a microcontroller bus where the low address byte and the data byte share one set of wires. It captures the address while the address-latch strobe is high and keeps it once the strobe drops. It decodes the chip-enable, write, data-read and program-fetch strobes and serves a byte-wide memory that occupies a programmable window of the 16-bit address space. Both read strobes are honoured, so the memory can hold program code and data alike.

The memory has two independent planes, and each plane is split into four sections. An 8-bit mask gives each of the eight sections its own write enable. An accepted write makes its plane busy for a fixed number of clock cycles. The byte is committed to the array when that time ends. While one plane is busy, the other plane still serves reads and accepts writes. With the default `SECT_AW = 7` a section is 128 bytes and the whole array is 1 KB. With `SECT_AW = 10` the geometry becomes two 4 KB planes made of 1 KB sections, and address bit 12 picks the plane.

All inputs are synchronous to `clk`. The window base and the section mask are loaded through a configuration strobe.

Top module: `dpmem_bus_slave`

## Requirements
- R1: At every clock edge where `ale` is 1, the latched address takes the value {`addr_hi`, `ad_in`}. While `ale` is 0 the latched address holds, whatever the bus then carries.
- R2: A write event happens at the clock edge where `wr_n` is sampled 1 after being sampled 0 at the previous edge, provided `ce_n` is 0 at that edge. The data written is `ad_in` at that edge. A write strobe with `ce_n` high has no effect.
- R3: `ad_oe` is 1 exactly when `ce_n` is 0, `rd_n` or `psen_n` is 0, and the latched address is inside the window. Both read strobes return the same data. When `ad_oe` is 0, `ad_out` is 0.
- R4: The window holds the addresses whose bits [15:SECT_AW+3] equal the configured base. Outside the window, writes are discarded and no read enables the bus.
- R5: Address bit SECT_AW+2 selects the plane, and bits [SECT_AW+2:SECT_AW] give the section index 0 to 7. Mask bit i enables section i. A write to a section whose mask bit is 0 is discarded, starts no busy period, and leaves the stored byte unchanged.
- R6: An accepted write keeps its plane busy for WRITE_CYCLES clock edges. The new byte is readable from the array once the busy period ends.
- R7: A read from a busy plane, at any offset, returns a status byte: bit 7 is the inverse of bit 7 of the pending data, and bits 6:0 are bits 6:0 of the pending data.
- R8: A read from the plane that is not busy returns its array contents, even while the other plane is busy.
- R9: A write to a busy plane is discarded and does not restart that plane's busy period. A write to the other, idle plane is accepted.
- R10: Reset clears both busy states, enables all eight sections and sets the base to 0. While `cfg_load` is 1 at a clock edge, the base is loaded from `cfg_base` and the mask from `cfg_wen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| ale | input | 1 | Address latch enable, active high |
| rd_n | input | 1 | Data-read strobe, active low |
| psen_n | input | 1 | Program-fetch strobe, active low |
| wr_n | input | 1 | Write strobe, active low; data is taken at its rising edge |
| addr_hi | input | 8 | Upper address byte (not multiplexed) |
| ad_in | input | 8 | Multiplexed bus, inbound: low address byte or write data |
| ad_out | output | 8 | Read data driven onto the bus |
| ad_oe | output | 1 | Bus output enable; when 0 the bus is left high-impedance |
| cfg_load | input | 1 | Loads the window base and the section mask |
| cfg_base | input | 16-SECT_AW-3 | Window base, compared with address bits [15:SECT_AW+3] |
| cfg_wen | input | 8 | Per-section write-enable mask |

## Verification
The read path is combinational from the latched address and the strobes. The bench therefore samples `ad_oe` and `ad_out` 1 ns after the falling edge at which it asserts a read strobe, and the address was latched one edge earlier. A write takes effect at the first rising edge where `wr_n` is seen high, and the plane stays busy for the next WRITE_CYCLES edges. Reads placed two edges after that event are still inside the busy period, so they must return the status byte. Array reads are made only after WRITE_CYCLES+2 idle cycles. Configuration values take effect one edge after `cfg_load`.

// File: rtl/dpmem_pkg.sv
package dpmem_pkg;

  // True when the address lies in the window selected by base
  function automatic logic win_hit(input logic [15:0] a, input logic [15:0] base,
                                   input int unsigned idx_w);
    return (a >> idx_w) == base;
  endfunction

  // Section index: three bits above the section offset
  function automatic logic [2:0] section_of(input logic [15:0] a, input int unsigned sect_aw);
    return 3'(a >> sect_aw);
  endfunction

  // Byte returned while a plane is busy
  function automatic logic [7:0] status_byte(input logic [7:0] d);
    return {~d[7], d[6:0]};
  endfunction

endpackage

// File: rtl/dpmem_bus_front.sv
module dpmem_bus_front (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        ale,
  input  logic        rd_n,
  input  logic        psen_n,
  input  logic        wr_n,
  input  logic [7:0]  addr_hi,
  input  logic [7:0]  ad_in,
  output logic [15:0] lat_addr,
  output logic        wr_evt,
  output logic [7:0]  wr_data,
  output logic        rd_act
);
  logic wr_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      wr_n_q   <= 1'b1;
    end else begin
      if (ale) lat_addr <= {addr_hi, ad_in};
      wr_n_q <= wr_n;
    end
  end

  assign wr_evt  = !wr_n_q && wr_n && !ce_n;
  assign wr_data = ad_in;
  assign rd_act  = !ce_n && (!rd_n || !psen_n);

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(lat_addr));
  // R1
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> lat_addr == $past({addr_hi, ad_in}));
  // R2
  wr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> $past(!wr_n));
endmodule

// File: rtl/dpmem_plane.sv
module dpmem_plane #(
  parameter int SECT_AW      = 7,
  parameter int WRITE_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic [SECT_AW+1:0]   wr_off,
  input  logic [7:0]           wr_data,
  input  logic [SECT_AW+1:0]   rd_off,
  output logic [7:0]           rd_data,
  output logic                 busy,
  output logic                 accept
);
  import dpmem_pkg::*;

  localparam int PA_W  = SECT_AW + 2;
  localparam int DEPTH = 1 << PA_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [PA_W-1:0]  p_off;
  logic [7:0]       p_dat;
  logic             commit;

  assign accept = wr_req && !busy;
  assign commit = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      p_off <= '0;
      p_dat <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= CNT_W'(WRITE_CYCLES);
      p_off <= wr_off;
      p_dat <= wr_data;
    end else if (busy) begin
      if (commit) busy <= 1'b0;
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[p_off] <= p_dat;
  end

  assign rd_data = busy ? status_byte(p_dat) : mem[rd_off];

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy && cnt == $past(cnt) - CNT_W'(1));
endmodule

// File: rtl/dpmem_bus_slave.sv
module dpmem_bus_slave #(
  parameter int SECT_AW      = 7,
  parameter int WRITE_CYCLES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    ale,
  input  logic                    rd_n,
  input  logic                    psen_n,
  input  logic                    wr_n,
  input  logic [7:0]              addr_hi,
  input  logic [7:0]              ad_in,
  output logic [7:0]              ad_out,
  output logic                    ad_oe,
  input  logic                    cfg_load,
  input  logic [16-SECT_AW-4:0]   cfg_base,
  input  logic [7:0]              cfg_wen
);
  import dpmem_pkg::*;

  localparam int IDX_W  = SECT_AW + 3;
  localparam int PA_W   = SECT_AW + 2;
  localparam int BASE_W = 16 - IDX_W;

  logic [15:0]       lat;
  logic              wr_evt, rd_act, hit, plane, sec_ok;
  logic [7:0]        wr_data;
  logic [2:0]        sec;
  logic [BASE_W-1:0] base_q;
  logic [7:0]        wen_q;
  logic [7:0]        rd_d [2];
  logic [1:0]        acc, bsy;

  dpmem_bus_front u_front (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ale(ale), .rd_n(rd_n),
    .psen_n(psen_n), .wr_n(wr_n), .addr_hi(addr_hi), .ad_in(ad_in),
    .lat_addr(lat), .wr_evt(wr_evt), .wr_data(wr_data), .rd_act(rd_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      wen_q  <= '1;
    end else if (cfg_load) begin
      base_q <= cfg_base;
      wen_q  <= cfg_wen;
    end
  end

  assign hit    = win_hit(lat, 16'(base_q), IDX_W);
  assign plane  = lat[IDX_W-1];
  assign sec    = section_of(lat, SECT_AW);
  assign sec_ok = wen_q[sec];

  for (genvar p = 0; p < 2; p++) begin : g_plane
    dpmem_plane #(.SECT_AW(SECT_AW), .WRITE_CYCLES(WRITE_CYCLES)) u_plane (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_evt && hit && sec_ok && (plane == 1'(p))),
      .wr_off(lat[PA_W-1:0]), .wr_data(wr_data),
      .rd_off(lat[PA_W-1:0]), .rd_data(rd_d[p]),
      .busy(bsy[p]), .accept(acc[p])
    );
  end

  assign ad_oe  = rd_act && hit;
  assign ad_out = ad_oe ? rd_d[plane] : 8'h00;

  // R3
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !ce_n && (!rd_n || !psen_n));
  // R4
  no_write_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> acc == 2'b00);
  // R5
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc != 2'b00) |-> wen_q[sec]);
  // R9
  single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc) && ((acc & bsy) == 2'b00));
  // R10
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> base_q == $past(cfg_base) && wen_q == $past(cfg_wen));
endmodule

// File: tb/dpmem_bus_slave_bench.sv
module dpmem_bus_slave_bench;
  localparam int CLK_P = 10;
  localparam int SAW   = 7;
  localparam int WC    = 8;
  localparam int IDX   = SAW + 3;

  logic clk = 0, rst_n = 0, ce_n = 0, ale = 0, rd_n = 1, psen_n = 1, wr_n = 1;
  logic [7:0] addr_hi = 0, ad_in = 0, cfg_wen = 8'hFF;
  logic [5:0] cfg_base = 0;
  logic cfg_load = 0;
  logic [7:0] ad_out;
  logic ad_oe;

  int n_tests = 0, n_fail = 0;
  logic [7:0] model [1024];
  bit         valid [1024];
  logic [7:0] wen_m = 8'hFF;
  logic [5:0] base_m = 0;

  always #(CLK_P/2) clk = ~clk;

  dpmem_bus_slave #(.SECT_AW(SAW), .WRITE_CYCLES(WC)) u_dpmem_bus_slave (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ale(ale), .rd_n(rd_n), .psen_n(psen_n),
    .wr_n(wr_n), .addr_hi(addr_hi), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .cfg_load(cfg_load), .cfg_base(cfg_base), .cfg_wen(cfg_wen)
  );

  function automatic logic [7:0] exp_status(input logic [7:0] d);
    exp_status = d ^ 8'h80;
  endfunction
  function automatic logic [2:0] exp_sec(input logic [15:0] a);
    exp_sec = a[9:7];
  endfunction
  function automatic bit exp_accept(input logic [15:0] a);
    exp_accept = (a[15:IDX] == base_m) && wen_m[exp_sec(a)];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [15:0] a);
    @(negedge clk); ale = 1; addr_hi = a[15:8]; ad_in = a[7:0];
    @(negedge clk); ale = 0; addr_hi = 8'hFF; ad_in = 8'h00;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    latch(a);
    wr_n = 0; ad_in = 8'hEE;
    @(negedge clk); wr_n = 1; ad_in = d;
    @(negedge clk); ad_in = 8'h00;
  endtask

  task automatic bus_read(input logic [15:0] a, input bit use_psen,
                          output logic oe, output logic [7:0] d);
    latch(a);
    if (use_psen) psen_n = 0; else rd_n = 0;
    #1; oe = ad_oe; d = ad_out;
    rd_n = 1; psen_n = 1;
  endtask

  task automatic cfg(input logic [5:0] b, input logic [7:0] m);
    @(negedge clk); cfg_load = 1; cfg_base = b; cfg_wen = m;
    @(negedge clk); cfg_load = 0; base_m = b; wen_m = m;
  endtask

  task automatic idle();
    repeat (WC + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic oe;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    #1; chk("R10 oe idle after reset", {7'b0, ad_oe}, 8'h00);
    rst_n = 1;

    // R10: base 0 after reset, section 7 writable
    bus_read(16'h0000, 0, oe, d);
    chk("R10 base 0 window", {7'b0, oe}, 8'h01);
    bus_write(16'h0380, 8'h3C);
    bus_read(16'h0380, 0, oe, d);
    chk("R10 section 7 enabled (status)", d, exp_status(8'h3C));
    idle();
    bus_read(16'h0380, 1, oe, d);
    chk("R6 committed byte via psen R3", d, 8'h3C);

    // move window to 0x1400
    cfg(6'h05, 8'hFF);
    bus_read(16'h0380, 0, oe, d);
    chk("R4 old window no oe", {7'b0, oe}, 8'h00);
    chk("R3 ad_out zero when off", d, 8'h00);

    // R2/R1: data captured at rising wr_n, address held
    bus_write(16'h1410, 8'hA5); model[10'h010] = 8'hA5; valid[10'h010] = 1;
    bus_write(16'h1610, 8'h5A); model[10'h210] = 8'h5A; valid[10'h210] = 1;
    idle();
    bus_read(16'h1410, 0, oe, d);
    chk("R2 data at wr_n rise / R1 held addr", d, 8'hA5);
    bus_read(16'h1610, 1, oe, d);
    chk("R3 psen read plane 1", d, 8'h5A);

    // R2: ce_n high ignored
    ce_n = 1; bus_write(16'h1410, 8'h11); ce_n = 0;
    bus_read(16'h1410, 0, oe, d);
    chk("R2 ce_n high write ignored", d, 8'hA5);
    ce_n = 1; bus_read(16'h1410, 0, oe, d); ce_n = 0;
    chk("R3 ce_n high no oe", {7'b0, oe}, 8'h00);

    // R4: write outside window discarded
    bus_write(16'h0010, 8'h77); idle();
    bus_read(16'h1410, 0, oe, d);
    chk("R4 outside write discarded", d, 8'hA5);

    // R7/R8
    bus_write(16'h1420, 8'h81);
    bus_read(16'h1610, 0, oe, d);
    chk("R8 other plane readable while busy", d, 8'h5A);
    bus_read(16'h1400, 0, oe, d);
    chk("R7 busy plane status", d, exp_status(8'h81));
    idle(); model[10'h020] = 8'h81; valid[10'h020] = 1;
    bus_read(16'h1420, 0, oe, d);
    chk("R6 committed after busy", d, 8'h81);

    // R9: write to busy plane ignored, other plane accepted
    bus_write(16'h1430, 8'h44);
    bus_write(16'h1410, 8'h99);
    bus_write(16'h1630, 8'h66);
    idle(); idle();
    model[10'h030] = 8'h44; valid[10'h030] = 1;
    model[10'h230] = 8'h66; valid[10'h230] = 1;
    bus_read(16'h1410, 0, oe, d);
    chk("R9 busy-plane write dropped", d, 8'hA5);
    bus_read(16'h1630, 0, oe, d);
    chk("R9 other plane accepted", d, 8'h66);
    bus_read(16'h1430, 0, oe, d);
    chk("R9 first write kept", d, 8'h44);

    // R5: section 2 (offset 0x100) disabled
    bus_write(16'h1500, 8'h12); idle();
    model[10'h100] = 8'h12; valid[10'h100] = 1;
    cfg(6'h05, 8'hFB);
    bus_write(16'h1500, 8'hF0);
    bus_read(16'h1500, 0, oe, d);
    chk("R5 masked write starts no busy", d, 8'h12);
    idle();
    bus_read(16'h1500, 0, oe, d);
    chk("R5 masked write discarded", d, 8'h12);

    // random phase
    void'($urandom(32'h5EED));
    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      logic [7:0] dv;
      if (i % 15 == 0) cfg(6'h05, 8'($urandom) | 8'h11);
      a  = {base_m, 10'($urandom)};
      dv = 8'($urandom);
      bus_write(a, dv);
      bus_read(a, i[0], oe, d);
      if (exp_accept(a))
        chk("R7 random busy status", d, exp_status(dv));
      else if (valid[a[9:0]])
        chk("R5 random masked no busy", d, model[a[9:0]]);
      if (exp_accept(a)) begin model[a[9:0]] = dv; valid[a[9:0]] = 1; end
      idle();
      bus_read(a, i[1], oe, d);
      if (valid[a[9:0]]) chk("R6 random readback", d, model[a[9:0]]);
    end

    finish_run();
  end
endmodule